// File: doc/BRIEF.md
# Width-Packing Card Data FIFO

This block sits between a register-access bus and a byte-serial card data port. It holds one byte FIFO for each direction. A single bus access of 1, 2 or 4 bytes packs that many bytes into the transmit FIFO, or unpacks that many bytes from the receive FIFO. The most significant byte of the access always travels first.

A transfer starts with a one-cycle `start` pulse. The pulse carries a direction and a byte count, and it empties both FIFOs. While the count is nonzero, the block moves at most one byte per clock. In write transfers, bytes go from the transmit FIFO to the card. In read transfers, bytes go from the card into the receive FIFO. Service requests ask the bus side to refill the transmit FIFO or to drain the receive FIFO.

When the count is used up, the block drops `active` and raises a done flag. A write transfer also raises a programming-done flag. A flush pulse discards whatever the transmit FIFO holds, so the bus can release a short buffer and begin again.

Top module: `card_data_fifo`

## Requirements
- R1: After a synchronous reset: `active`, `done`, `prog_done`, `tx_req`, `rx_req`, `tx_valid` and `rx_ready` are 0, `bus_rdata` is 0, and both FIFOs are empty.
- R2: `bus_size` gives the access width: 0 is 1 byte, 1 is 2 bytes, 2 and 3 are 4 bytes. On a `bus_wr` of width N, byte lane N-1 (bits 8N-1..8N-8) enters the transmit FIFO first and lane 0 enters last. The card receives the bytes in that order.
- R3: The transmit FIFO holds at most DEPTH (32) bytes. Bytes of a bus write that find it full are dropped, and the bytes already queued are kept.
- R4: A `bus_rd` of width N pops up to N bytes. One cycle later, `bus_rdata` holds the first popped byte in lane N-1, the next in lane N-2, and so on. Lanes with no byte available, and lanes at or above N, read 0.
- R5: In a write transfer (`start_write`=1), `tx_valid` is high exactly when bytes remain in the count and the transmit FIFO is not empty. Each `tx_valid && tx_ready` cycle moves one byte, and exactly the programmed count of bytes reaches the card.
- R6: In a read transfer (`start_write`=0), `rx_ready` is high exactly when bytes remain and the receive FIFO holds fewer than DEPTH bytes. Each `rx_valid && rx_ready` cycle stores one byte.
- R7: During a write transfer, `tx_req` rises when the transmit FIFO runs empty while bytes are still outstanding. A bus write clears it.
- R8: `rx_req` rises on each cycle in which a byte is taken from the card. A bus read clears it, unless a byte arrives in that same cycle.
- R9: One cycle after the count reaches 0, `active` falls and `done` rises. `prog_done` also rises, but only for a write transfer. `start` clears both flags and both requests.
- R10: A `flush` pulse empties the transmit FIFO and moves its start point by half the depth. Bytes queued before the flush never reach the card.
- R11: Both FIFOs wrap around at DEPTH entries. A transfer longer than DEPTH keeps its byte order across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer and empty both FIFOs |
| start_write | input | 1 | Transfer direction: 1 means toward the card |
| start_count | input | CNT_W | Number of bytes in the transfer |
| flush | input | 1 | Discard the transmit contents and shift its start by DEPTH/2 |
| bus_wr | input | 1 | Bus write into the transmit FIFO |
| bus_rd | input | 1 | Bus read from the receive FIFO |
| bus_size | input | 2 | Access width code |
| bus_wdata | input | 8*LANES | Write data |
| bus_rdata | output | 8*LANES | Read data, registered |
| tx_data | output | 8 | Byte toward the card |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | Card accepts the byte |
| rx_data | input | 8 | Byte from the card |
| rx_valid | input | 1 | `rx_data` is valid |
| rx_ready | output | 1 | Block accepts the byte |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |
| active | output | 1 | Transfer in progress |
| done | output | 1 | Transfer complete |
| prog_done | output | 1 | Write transfer complete |

## Verification
The bench builds the block with its default parameters: DEPTH 32, LANES 4 and CNT_W 16. A 40-byte transfer is therefore longer than either FIFO. In the write direction, nine word writes overrun the 32-byte limit and the card then drains the FIFO past the wrap point. In the read direction, the receive FIFO fills completely, `rx_ready` is seen to stall, and the bus then drains it across the wrap. The 4-byte lane count lets the bench try every access width, including reads that find only part of a word available.

// File: rtl/card_fifo_pkg.sv
package card_fifo_pkg;
  // Access width codes on bus_size.
  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_WIDE = 2'd3
  } acc_size_e;

  // Number of bytes moved by an access, limited to the lane count.
  function automatic int acc_bytes(input logic [1:0] sz, input int lanes);
    int n;
    case (acc_size_e'(sz))
      ACC_BYTE: n = 1;
      ACC_HALF: n = 2;
      default:  n = 4;
    endcase
    return (n > lanes) ? lanes : n;
  endfunction
endpackage

// File: rtl/cfifo_bytes.sv
module cfifo_bytes #(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1,
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  flip,
  input  logic [CW-1:0]         push_req,
  input  logic [LANES-1:0][7:0] push_byte,
  input  logic [CW-1:0]         pop_req,
  output logic [CW-1:0]         push_cnt,
  output logic [CW-1:0]         pop_cnt,
  output logic [LW-1:0]         lvl,
  output logic [LANES-1:0][7:0] peek
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rd_ptr;
  logic [LW-1:0] space, push_w, pop_w;
  logic [AW-1:0] wr_base;

  always_comb begin
    space   = LW'(DEPTH) - lvl;
    push_w  = (LW'(push_req) > space) ? space : LW'(push_req);
    pop_w   = (LW'(pop_req) > lvl) ? lvl : LW'(pop_req);
    wr_base = rd_ptr + lvl[AW-1:0];
  end

  assign push_cnt = CW'(push_w);
  assign pop_cnt  = CW'(pop_w);

  // Storage: several lanes may be written in one cycle.
  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (LW'(k) < push_w) mem[wr_base + AW'(k)] <= push_byte[k];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_peek
    assign peek[g] = mem[rd_ptr + AW'(g)];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rd_ptr <= '0;
      lvl    <= '0;
    end else if (flip) begin
      rd_ptr <= rd_ptr ^ AW'(DEPTH / 2);
      lvl    <= '0;
    end else begin
      rd_ptr <= rd_ptr + pop_w[AW-1:0];
      lvl    <= lvl + push_w - pop_w;
    end
  end
endmodule

// File: rtl/cxfer_ctrl.sv
module cxfer_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_write,
  input  logic [CNT_W-1:0] start_count,
  input  logic             moved,
  input  logic             tx_dry,
  input  logic             bus_wr,
  input  logic             bus_rd,
  output logic             active,
  output logic             xfer_dir,
  output logic             rem_nz,
  output logic             tx_req,
  output logic             rx_req,
  output logic             done,
  output logic             prog_done
);
  logic [CNT_W-1:0] rem, rem_next;

  assign rem_nz   = (rem != '0);
  assign rem_next = rem - CNT_W'(moved);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0; xfer_dir <= 1'b0; rem <= '0;
      done <= 1'b0; prog_done <= 1'b0; tx_req <= 1'b0; rx_req <= 1'b0;
    end else if (start) begin
      active <= 1'b1; xfer_dir <= start_write; rem <= start_count;
      done <= 1'b0; prog_done <= 1'b0; tx_req <= 1'b0; rx_req <= 1'b0;
    end else begin
      if (active) begin
        if (!rem_nz) begin
          active <= 1'b0;
          done   <= 1'b1;
          if (xfer_dir) prog_done <= 1'b1;
        end else begin
          rem <= rem_next;
        end
      end
      if (active && xfer_dir && rem_nz && (rem_next != '0) && tx_dry) tx_req <= 1'b1;
      else if (bus_wr) tx_req <= 1'b0;
      if (active && !xfer_dir && moved) rx_req <= 1'b1;
      else if (bus_rd) rx_req <= 1'b0;
    end
  end
endmodule

// File: rtl/card_data_fifo.sv
module card_data_fifo
  import card_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  parameter int CNT_W = 16,
  localparam int BW = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_write,
  input  logic [CNT_W-1:0] start_count,
  input  logic             flush,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_size,
  input  logic [BW-1:0]    bus_wdata,
  output logic [BW-1:0]    bus_rdata,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  input  logic [7:0]       rx_data,
  input  logic             rx_valid,
  output logic             rx_ready,
  output logic             tx_req,
  output logic             rx_req,
  output logic             active,
  output logic             done,
  output logic             prog_done
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam int CW = $clog2(LANES + 1);

  logic [LW-1:0]         tx_lvl, rx_lvl;
  logic [CW-1:0]         tx_push_req, tx_pop_req, rx_push_req, rx_pop_req;
  logic [CW-1:0]         tx_push_cnt, tx_pop_cnt, rx_push_cnt, rx_pop_cnt;
  logic [LANES-1:0][7:0] tx_in, rx_in, tx_peek, rx_peek;
  logic [BW-1:0]         rd_word;
  logic                  xfer_dir, rem_nz, moved, tx_dry;
  int                    nbytes;

  assign nbytes = acc_bytes(bus_size, LANES);

  // Most significant lane of the access enters first.
  always_comb begin
    tx_in = '0;
    for (int k = 0; k < LANES; k++) begin
      if (k < nbytes) tx_in[k] = bus_wdata[8*(nbytes-1-k) +: 8];
    end
    rx_in    = '0;
    rx_in[0] = rx_data;
  end

  assign tx_valid    = active && xfer_dir && rem_nz && (tx_lvl != '0);
  assign rx_ready    = active && !xfer_dir && rem_nz && (rx_lvl < LW'(DEPTH));
  assign tx_data     = tx_peek[0];
  assign moved       = (tx_valid && tx_ready) || (rx_valid && rx_ready);
  assign tx_push_req = bus_wr ? CW'(nbytes) : '0;
  assign tx_pop_req  = CW'(tx_valid && tx_ready);
  assign rx_push_req = CW'(rx_valid && rx_ready);
  assign rx_pop_req  = bus_rd ? CW'(nbytes) : '0;
  assign tx_dry      = (tx_lvl + LW'(tx_push_cnt) - LW'(tx_pop_cnt)) == '0;

  cfifo_bytes #(.DEPTH(DEPTH), .LANES(LANES)) u_txq (
    .clk(clk), .rst(rst), .clr(start), .flip(flush),
    .push_req(tx_push_req), .push_byte(tx_in), .pop_req(tx_pop_req),
    .push_cnt(tx_push_cnt), .pop_cnt(tx_pop_cnt), .lvl(tx_lvl), .peek(tx_peek)
  );

  cfifo_bytes #(.DEPTH(DEPTH), .LANES(LANES)) u_rxq (
    .clk(clk), .rst(rst), .clr(start), .flip(1'b0),
    .push_req(rx_push_req), .push_byte(rx_in), .pop_req(rx_pop_req),
    .push_cnt(rx_push_cnt), .pop_cnt(rx_pop_cnt), .lvl(rx_lvl), .peek(rx_peek)
  );

  cxfer_ctrl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst(rst), .start(start), .start_write(start_write),
    .start_count(start_count), .moved(moved), .tx_dry(tx_dry),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .active(active), .xfer_dir(xfer_dir),
    .rem_nz(rem_nz), .tx_req(tx_req), .rx_req(rx_req), .done(done),
    .prog_done(prog_done)
  );

  // First popped byte lands in the most significant lane of the access.
  always_comb begin
    rd_word = '0;
    for (int k = 0; k < LANES; k++) begin
      if (k < int'(rx_pop_cnt)) rd_word[8*(nbytes-1-k) +: 8] = rx_peek[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  logic unused_sig;
  assign unused_sig = ^{tx_peek[LANES-1:1], rx_push_cnt};
endmodule

// File: rtl/card_fifo_chk.sv
module card_fifo_chk #(
  parameter int DEPTH = 32,
  parameter int LW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          tx_valid,
  input logic          rx_ready,
  input logic          active,
  input logic          done,
  input logic          prog_done,
  input logic          xfer_dir,
  input logic [LW-1:0] tx_lvl,
  input logic [LW-1:0] rx_lvl
);
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_lvl <= LW'(DEPTH)) && (rx_lvl <= LW'(DEPTH)));
  // R5
  tx_dir_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (active && xfer_dir && tx_lvl != '0));
  // R6
  rx_full_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_lvl == LW'(DEPTH)) |-> !rx_ready);
  // R9
  done_after_active_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(active));
  // R9
  prog_implies_done_chk: assert property (@(posedge clk) disable iff (rst)
    prog_done |-> done);
  // R9
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (active && !done && !prog_done));
endmodule

bind card_data_fifo card_fifo_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .tx_valid(tx_valid), .rx_ready(rx_ready),
  .active(active), .done(done), .prog_done(prog_done), .xfer_dir(xfer_dir),
  .tx_lvl(tx_lvl), .rx_lvl(rx_lvl)
);

// File: tb/sim_card_data_fifo.sv
`timescale 1ns/1ps
module sim_card_data_fifo;
  localparam int CLK_NS = 4;
  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic        rst = 1'b1, start = 0, start_write = 0, flush = 0;
  logic [15:0] start_count = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0]  tx_data, rx_data = 8'hA0;
  logic        tx_valid, tx_ready = 0, rx_valid = 0, rx_ready;
  logic        tx_req, rx_req, active, done, prog_done;

  card_data_fifo u0 (.*);

  int n_chk = 0, n_fail = 0, n_tx = 0, room = 32;
  logic [7:0] exp_q[$];
  logic [7:0] rx_next;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: card-side bytes against expected queue (R2, R5, R11).
  initial forever begin
    @(negedge clk);
    if (tx_valid && tx_ready) begin
      n_tx++;
      if (exp_q.size() == 0) chk("R5 unexpected card byte", {24'd0, tx_data}, 32'hxx);
      else chk("R2 R11 card byte order", {24'd0, tx_data}, {24'd0, exp_q.pop_front()});
    end
  end

  // Card source: advance rx_data after each accepted byte.
  initial forever begin
    logic hs;
    @(negedge clk);
    hs = rx_valid && rx_ready;
    @(posedge clk); #1;
    if (hs) rx_data = rx_data + 8'd1;
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_start(input logic wr, input logic [15:0] cnt);
    start = 1; start_write = wr; start_count = cnt;
    cyc(1);
    start = 0;
  endtask

  // Bus write; expected bytes pushed MSB first while model room lasts.
  task automatic bus_write(input logic [1:0] sz, input logic [31:0] d, input bit keep);
    int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    bus_wr = 1; bus_size = sz; bus_wdata = d;
    for (int k = n - 1; k >= 0; k--) begin
      if (keep && room > 0) begin
        exp_q.push_back(d[8*k +: 8]);
        room--;
      end
    end
    cyc(1);
    bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] sz, input logic [31:0] exp, input string tag);
    bus_rd = 1; bus_size = sz;
    cyc(1);
    bus_rd = 0;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
    cyc(0);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 400 && !done; i++) @(negedge clk);
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base;
    cyc(3);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 flags", {active, done, prog_done, tx_req, rx_req, tx_valid, rx_ready}, 0);
    chk("R1 rdata", bus_rdata, 0);
    cyc(0);

    // Write transfer of 7 bytes with mixed widths (R2, R5, R7, R9)
    do_start(1'b1, 16'd7);
    cyc(2);
    @(negedge clk); chk("R7 tx_req when dry", tx_req, 1); cyc(0);
    room = 32;
    bus_write(2'd2, 32'h11223344, 1);
    @(negedge clk); chk("R7 tx_req cleared by write", tx_req, 0); cyc(0);
    bus_write(2'd1, 32'hFFFFAABB, 1);
    bus_write(2'd0, 32'hFFFFFFCC, 1);
    tx_ready = 1;
    wait_done();
    @(negedge clk);
    chk("R5 byte count", n_tx, 7);
    chk("R9 done", done, 1);
    chk("R9 prog_done on write", prog_done, 1);
    chk("R9 active low", active, 0);
    cyc(0);

    // Overflow and wrap: 40-byte write transfer (R3, R7, R11)
    tx_ready = 0; n_tx = 0;
    do_start(1'b1, 16'd40);
    @(negedge clk); chk("R9 start clears done", done, 0); cyc(0);
    room = 32;
    for (int w = 0; w < 9; w++)
      bus_write(2'd2, {8'(4*w), 8'(4*w+1), 8'(4*w+2), 8'(4*w+3)}, 1);
    chk("R3 accepted bytes", exp_q.size(), 32);
    tx_ready = 1;
    cyc(36);
    @(negedge clk);
    chk("R3 drained 32", n_tx, 32);
    chk("R7 tx_req outstanding", tx_req, 1);
    chk("R5 tx_valid low when empty", tx_valid, 0);
    cyc(0);
    room = 32;
    bus_write(2'd2, 32'h80818283, 1);
    bus_write(2'd2, 32'h84858687, 1);
    wait_done();
    chk("R11 total bytes", n_tx, 40);
    chk("R11 scoreboard empty", exp_q.size(), 0);

    // Flush discards queued bytes (R10)
    tx_ready = 0; n_tx = 0;
    do_start(1'b1, 16'd2);
    bus_write(2'd1, 32'h00005566, 0);
    flush = 1; cyc(1); flush = 0;
    room = 32;
    bus_write(2'd1, 32'h00007788, 1);
    tx_ready = 1;
    wait_done();
    chk("R10 bytes after flush", n_tx, 2);
    chk("R10 scoreboard empty", exp_q.size(), 0);
    tx_ready = 0;

    // Read transfer of 6 bytes (R4, R6, R8, R9)
    rx_data = 8'hA0; rx_valid = 1;
    do_start(1'b0, 16'd6);
    wait_done();
    @(negedge clk);
    chk("R9 done on read", done, 1);
    chk("R9 no prog_done on read", prog_done, 0);
    chk("R8 rx_req set", rx_req, 1);
    cyc(0);
    bus_read(2'd1, 32'h0000A0A1, "R4 half read");
    chk("R8 rx_req cleared", rx_req, 0);
    bus_read(2'd0, 32'h000000A2, "R4 byte read");
    bus_read(2'd2, 32'hA3A4A500, "R4 partial word zero lane");
    bus_read(2'd2, 32'h00000000, "R4 empty read");

    // Long read: FIFO fills, stalls, then wraps (R6, R11)
    rx_next = rx_data;
    do_start(1'b0, 16'd40);
    cyc(45);
    @(negedge clk);
    chk("R6 rx_ready stalls when full", rx_ready, 0);
    chk("R6 still active", active, 1);
    cyc(0);
    for (int r = 0; r < 10; r++) begin
      base = 4 * r;
      bus_read(2'd2, {rx_next + 8'(base), rx_next + 8'(base+1),
                      rx_next + 8'(base+2), rx_next + 8'(base+3)}, "R11 read wrap order");
      cyc(2);
    end
    wait_done();
    chk("R9 long read done", done, 1);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule